// File: doc/BRIEF.md
# Radix-4 Booth Partial-Product Row Generator

This block is the front end of a radix-4 Booth multiplier. It reads the multiplier operand two bits at a time, in overlapping triplets, and recodes each triplet into one digit from the set {-2, -1, 0, +1, +2}. For each digit it raises four flags: sign, unit magnitude, double magnitude and null. It uses those flags to build one partial-product row from the multiplicand. Each row is already sign-extended to the full product width and shifted to its weight of 4^k. A row with a negative digit is delivered in one's complement. The missing +1 for that row leaves the block as a separate correction bit, which a downstream compressor tree injects at the row's least significant position.

A mode input chooses between two's-complement operands and unsigned operands. In unsigned mode both operands are zero-extended. One more triplet then covers the multiplier's top bit, so that the last digit can never be negative. In signed mode that extra triplet is held inactive. The block has one register stage: the operands and the mode are sampled on a rising clock edge, and every output is registered. Adding up the rows and the final carry-propagate addition are left to the blocks that follow.

Top module: `booth_pp_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are: all rows zero, `neg_o`, `one_o` and `two_o` zero, and every bit of `zero_o` set.
- R2: Outside reset, every output in a cycle reflects the `mcand`, `mplier` and `is_signed` values sampled at the preceding rising edge.
- R3: Group k reads the triplet (y[2k+1], y[2k], y[2k-1]), with y[-1] = 0. The triplet maps to a digit: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, 101 and 110 give -1. `zero_o[k]`, `one_o[k]` and `two_o[k]` mark digit magnitude 0, 1 and 2, and exactly one of them is set.
- R4: `neg_o[k]` is set exactly when digit k is negative, that is for triplets 100, 101 and 110.
- R5: Row k occupies `rows_o[k*2W +: 2W]`. It is built in four steps. First, the multiplicand is extended to W+2 bits (sign-extended in signed mode, zero-extended in unsigned mode). Second, that value is multiplied by the magnitude of digit k. Third, the result is bitwise inverted when the digit is negative. Finally, it is sign-extended from bit W+1 to 2W bits and shifted left by 2k, keeping the low 2W bits.
- R6: A row whose `zero_o` flag is set is all zeros.
- R7: With `is_signed` = 1, the top group (index W/2) is inactive: its row is zero, `zero_o` is set and `neg_o` is clear.
- R8: With `is_signed` = 0, the multiplier is zero-extended by two bits. The top group then reads (0, 0, y[W-1]) and never raises `neg_o`.
- R9: The sum over k of row k plus `neg_o[k]`·4^k, taken modulo 2^(2W), equals the product of the sampled operands. The product is signed or unsigned according to `is_signed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier, recoded two bits per group |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned operands |
| rows_o | output | (W/2+1)·2W | Aligned, sign-extended rows; row k at bits k·2W upward |
| neg_o | output | W/2+1 | Per-group negative-digit flag and +1 correction bit |
| one_o | output | W/2+1 | Per-group digit magnitude 1 |
| two_o | output | W/2+1 | Per-group digit magnitude 2 |
| zero_o | output | W/2+1 | Per-group digit magnitude 0 |

## Verification
The bench builds the block with W = 16, which gives nine groups and 32-bit rows. At this width a single cycle can reach the signed extremes -32768 × -32768 and the unsigned extreme 65535 × 65535. The unsigned case takes doubled multiplicands up to 131070, where the two guard bits of the row field are needed. The directed products include the most negative operand, alternating bit patterns and all-ones multipliers, which between them visit every triplet code. A long random run alternates the two modes, so that the top group moves from forced idle to active from one cycle to the next.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
    logic zero;
  } booth_dec_t;

  localparam booth_dec_t DEC_IDLE = '{neg: 1'b0, one: 1'b0, two: 1'b0, zero: 1'b1};

endpackage

// File: rtl/booth_group_enc.sv
module booth_group_enc
  import booth_pkg::*;
(
  input  logic [2:0]  trip,
  input  logic        active,
  output booth_dec_t  dec
);

  always_comb begin
    dec = DEC_IDLE;
    if (active) begin
      unique case (trip)
        3'b001, 3'b010: dec = '{neg: 1'b0, one: 1'b1, two: 1'b0, zero: 1'b0};
        3'b011:         dec = '{neg: 1'b0, one: 1'b0, two: 1'b1, zero: 1'b0};
        3'b100:         dec = '{neg: 1'b1, one: 1'b0, two: 1'b1, zero: 1'b0};
        3'b101, 3'b110: dec = '{neg: 1'b1, one: 1'b1, two: 1'b0, zero: 1'b0};
        default:        dec = DEC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/booth_row_sel.sv
module booth_row_sel
  import booth_pkg::*;
#(
  parameter int W     = 16,
  parameter int PRODW = 32,
  parameter int SHIFT = 0
) (
  input  logic [W+1:0]     xext,
  input  booth_dec_t       dec,
  output logic [PRODW-1:0] row
);

  localparam int ROWW = W + 2;
  localparam int EXTW = PRODW - ROWW;

  logic [ROWW-1:0]  sel;
  logic [ROWW-1:0]  inv;
  logic [PRODW-1:0] sext;

  always_comb begin
    if (dec.one)      sel = xext;
    else if (dec.two) sel = {xext[W:0], 1'b0};
    else              sel = '0;
    inv  = dec.neg ? ~sel : sel;
    sext = {{EXTW{inv[ROWW-1]}}, inv};
    row  = sext << SHIFT;
  end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [W-1:0]                 mcand,
  input  logic [W-1:0]                 mplier,
  input  logic                         is_signed,
  output logic [(W/2+1)*(2*W)-1:0]     rows_o,
  output logic [W/2:0]                 neg_o,
  output logic [W/2:0]                 one_o,
  output logic [W/2:0]                 two_o,
  output logic [W/2:0]                 zero_o
);

  localparam int NGRP  = W/2 + 1;
  localparam int PRODW = 2*W;
  localparam int TOPG  = NGRP - 1;

  logic [W+1:0]            xext;
  logic [W+2:0]            yext;
  logic [1:0]              ytop;
  logic [NGRP*PRODW-1:0]   rows_d;
  booth_dec_t              dec [NGRP];

  always_comb begin
    ytop = is_signed ? {2{mplier[W-1]}} : 2'b00;
    yext = {ytop, mplier, 1'b0};
    xext = is_signed ? {{2{mcand[W-1]}}, mcand} : {2'b00, mcand};
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic act;
    assign act = (g < TOPG) ? 1'b1 : ~is_signed;

    booth_group_enc u_enc (
      .trip   (yext[2*g+2:2*g]),
      .active (act),
      .dec    (dec[g])
    );

    booth_row_sel #(.W(W), .PRODW(PRODW), .SHIFT(2*g)) u_row (
      .xext (xext),
      .dec  (dec[g]),
      .row  (rows_d[g*PRODW +: PRODW])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        neg_o[g]  <= 1'b0;
        one_o[g]  <= 1'b0;
        two_o[g]  <= 1'b0;
        zero_o[g] <= 1'b1;
        rows_o[g*PRODW +: PRODW] <= '0;
      end else begin
        neg_o[g]  <= dec[g].neg;
        one_o[g]  <= dec[g].one;
        two_o[g]  <= dec[g].two;
        zero_o[g] <= dec[g].zero;
        rows_o[g*PRODW +: PRODW] <= rows_d[g*PRODW +: PRODW];
      end
    end

    // R3: exactly one magnitude flag per group
    p_mag_onehot_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot({one_o[g], two_o[g], zero_o[g]}));

    // R4: a negative digit never has zero magnitude
    p_neg_nonnull_r4: assert property (@(posedge clk) disable iff (rst)
      neg_o[g] |-> !zero_o[g]);

    // R6: null digit gives an all-zero row
    p_null_row_r6: assert property (@(posedge clk) disable iff (rst)
      zero_o[g] |-> (rows_o[g*PRODW +: PRODW] == '0));
  end

  // R7: signed mode leaves the extra group idle
  p_top_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_signed)) |-> (zero_o[TOPG] && !neg_o[TOPG]));

  // R8: the extra group never carries a negative digit
  p_top_nonneg_r8: assert property (@(posedge clk) disable iff (rst)
    !neg_o[TOPG]);

endmodule

// File: tb/booth_pp_gen_bench.sv
module booth_pp_gen_bench;

  localparam int W  = 16;
  localparam int NG = W/2 + 1;
  localparam int PW = 2*W;

  logic                 clk = 1'b0;
  logic                 rst;
  logic [W-1:0]         a, b;
  logic                 sgn;
  logic [NG*PW-1:0]     rows;
  logic [NG-1:0]        neg, one, two, zro;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         s;
  } stim_t;

  stim_t q[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  always #4 clk = ~clk;

  booth_pp_gen #(.W(W)) u_booth_pp_gen (
    .clk(clk), .rst(rst), .mcand(a), .mplier(b), .is_signed(sgn),
    .rows_o(rows), .neg_o(neg), .one_o(one), .two_o(two), .zero_o(zro)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ybit(input logic [W-1:0] y, input logic s, input int j);
    if (j < 0)  return 0;
    if (j < W)  return int'(y[j]);
    return s ? int'(y[W-1]) : 0;
  endfunction

  task automatic check_vec(input stim_t t);
    longint xv, yv, prod, sum;
    logic [PW-1:0] got_sum, exp_prod;
    xv = t.s ? longint'($signed(t.a)) : longint'(t.a);
    yv = t.s ? longint'($signed(t.b)) : longint'(t.b);
    prod = xv * yv;
    sum = 0;
    for (int k = 0; k < NG; k++) begin
      int d, mag;
      longint selv, v;
      logic [63:0] full;
      logic [PW-1:0] exp_row, got_row;
      if (k == NG-1 && t.s) d = 0;
      else d = -2*ybit(t.b, t.s, 2*k+1) + ybit(t.b, t.s, 2*k) + ybit(t.b, t.s, 2*k-1);
      mag  = (d < 0) ? -d : d;
      selv = longint'(mag) * xv;
      v    = (d < 0) ? (-selv - 1) : selv;
      full = 64'(v) << (2*k);
      exp_row = full[PW-1:0];
      got_row = rows[k*PW +: PW];
      chk(got_row == exp_row, "R5/R2", $sformatf("row %0d", k), longint'(got_row), longint'(exp_row));
      chk(zro[k] == (mag == 0), (k == NG-1) ? "R3/R7/R8" : "R3", $sformatf("zero %0d", k), longint'(zro[k]), longint'(mag == 0));
      chk(one[k] == (mag == 1), "R3", $sformatf("one %0d", k), longint'(one[k]), longint'(mag == 1));
      chk(two[k] == (mag == 2), "R3", $sformatf("two %0d", k), longint'(two[k]), longint'(mag == 2));
      chk(neg[k] == (d < 0), (k == NG-1) ? "R4/R8" : "R4", $sformatf("neg %0d", k), longint'(neg[k]), longint'(d < 0));
      if (zro[k]) chk(got_row == '0, "R6", $sformatf("null row %0d", k), longint'(got_row), 0);
      sum += longint'(got_row) + (longint'(neg[k]) << (2*k));
    end
    got_sum  = sum[PW-1:0];
    exp_prod = prod[PW-1:0];
    chk(got_sum == exp_prod, "R9", $sformatf("sum %0h*%0h s=%0d", t.a, t.b, t.s),
        longint'(got_sum), longint'(exp_prod));
  endtask

  task automatic step(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vs);
    stim_t t;
    @(negedge clk);
    if (q.size() > 0) check_vec(q.pop_front());
    a = va; b = vb; sgn = vs;
    t.a = va; t.b = vb; t.s = vs;
    q.push_back(t);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; a = 16'h1234; b = 16'hBEEF; sgn = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(rows == '0, "R1", "rows", longint'(rows[63:0]), 0);
    chk(neg == '0, "R1", "neg", longint'(neg), 0);
    chk(one == '0, "R1", "one", longint'(one), 0);
    chk(two == '0, "R1", "two", longint'(two), 0);
    chk(zro == '1, "R1", "zero", longint'(zro), longint'({NG{1'b1}}));
    rst = 1'b0;

    step(16'd3, 16'd3, 1'b1);
    step(16'd3083, 16'd3083, 1'b1);
    step(-16'sd4093, -16'sd4093, 1'b1);
    step(-16'sd1989, -16'sd1989, 1'b1);
    step(16'h8000, 16'h8000, 1'b1);
    step(16'h7FFF, 16'h8000, 1'b1);
    step(16'hFFFF, 16'hFFFF, 1'b1);
    step(16'hFFFF, 16'hFFFF, 1'b0);
    step(16'h8000, 16'hFFFF, 1'b0);
    step(16'hAAAA, 16'h5555, 1'b0);
    step(16'h5555, 16'hAAAA, 1'b1);
    step(16'hFFFF, 16'h6666, 1'b0);
    step(16'h0000, 16'hFFFF, 1'b0);
    step(16'h1234, 16'h0000, 1'b1);
    step(16'h8001, 16'hCCCC, 1'b0);
    for (int i = 0; i < 3000; i++)
      step(16'($urandom), 16'($urandom), 1'($urandom));
    @(negedge clk);
    if (q.size() > 0) check_vec(q.pop_front());

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule